// File: doc/BRIEF.md
# Command-then-data serial master

This block drives a half-duplex serial link in which every transaction opens with a command word sent by the master and continues with a number of data words that either travel out to the peripheral or come back from it. The select line is active low and rests high; the serial clock rests low and, outside free-running operation, only moves while bits are being exchanged. A request is accepted on a valid/ready handshake that carries the command, the number of data words and the direction. Received words come out on a one-cycle valid strobe, and words to transmit are pulled from an input bus with a one-cycle take strobe.

Four framing options are chosen per request. In plain operation the command and each data word form separate frames, with select high for one serial period between them. The gap option stretches that pause to two serial periods. The free-running option keeps the serial clock toggling at all times, even with select high, and frames as in plain operation. The join option holds select low from the first command bit to the last data bit, so that the command and all its data form a single long frame.

The serial clock period is a parameter, given in system clocks. Bits change on the falling edge of the serial clock and are sampled on the rising edge.

Top module: `cmdser_master`

## Requirements
- R1: After reset, and whenever no request is in progress, `ss_n` is 1, `done` and `rx_valid` are 0 and `start_ready` is 1; outside free-running operation `sclk` is 0.
- R2: The command is shifted out on `mosi` most significant bit first, one bit per serial period. `mosi` changes only while `sclk` is low, and it holds its value across every high phase of `sclk`.
- R3: When `start_write` is 0 (read), one serial period with the clock running and no sampling follows the command before the first received bit. Each received word is assembled from `miso` sampled on rising `sclk` edges, most significant bit first. It is presented on `rx_data` with `rx_valid` high for exactly one cycle, and `rx_valid` never rises during a write.
- R4: When `start_write` is 1, each data word is taken from `tx_word` in the cycle where `tx_take` is high, once per word. It is shifted out most significant bit first, with no turnaround period after the command.
- R5: `mode` 2'b00 (plain): the command and every data word each have their own select assertion, separated by exactly 2*HALF_CYC system clocks with `ss_n` high, and `sclk` stays low while `ss_n` is high.
- R6: `mode` 2'b01 (gap): the pause between frames lasts exactly 4*HALF_CYC system clocks with `ss_n` high.
- R7: `mode` 2'b10 (free-running): `sclk` toggles every HALF_CYC system clocks, also while idle and while `ss_n` is high, and frames are separated as in R5.
- R8: `mode` 2'b11 (join): `ss_n` falls once and stays low from the first command bit until after the last data bit.
- R9: `done` is high for exactly one cycle, the cycle in which `ss_n` returns high after the last frame of a request.
- R10: A request is taken only while `start_ready` is 1; `start_valid` pulsed during a transaction starts nothing and alters nothing on the wire.
- R11: A request with a data count of 0 produces the command frame alone, with no turnaround and no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Request strobe |
| start_ready | output | 1 | High while idle and able to take a request |
| start_cmd | input | CMD_W | Command word to send |
| start_count | input | CNT_W | Number of data words after the command |
| start_write | input | 1 | 1: data words are sent, 0: data words are received |
| mode | input | 2 | Framing option: 00 plain, 01 gap, 10 free-running, 11 join |
| tx_word | input | DATA_W | Next data word to transmit |
| tx_take | output | 1 | One-cycle strobe: `tx_word` is taken in this cycle |
| rx_data | output | DATA_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` is new |
| done | output | 1 | One-cycle strobe at the end of a request |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low select |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The assertions check on every cycle that the clock stays low under a released select outside free-running operation and that `mosi` holds through each high clock phase. They also check that `done` is a single cycle coinciding with select release, that join framing keeps select low for the whole transaction, that received words never appear during a write, and that the clock phase follows its tick. Only the bench scenarios can show the bit content and order of commands and words, the presence of the turnaround slot, the exact gap lengths per option, the number of select assertions per request, the count-zero case and the refusal of a request while busy. The bench does this through a peripheral model on the serial pins and a scoreboard of expected received words.

// File: rtl/cmdser_pkg.sv
// Shared types for the command-then-data serial master.
// Assumes: mode codes are fixed by the top-level port encoding.
package cmdser_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_GAP2  = 2'd1,
        MODE_FREE  = 2'd2,
        MODE_JOIN  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_CMD,
        ST_GAP,
        ST_TURN,
        ST_DATA
    } state_e;

endpackage

// File: rtl/cmdser_clkgen.sv
// Serial clock phase generator.
// Runs from reset, independent of any transaction, so free-running mode
// and framed mode share one time base. tick_rise marks the last system
// cycle before the phase goes high, tick_fall the last before it goes low.
// Assumes: HALF_CYC >= 1.
module cmdser_clkgen #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic ph,
    output logic tick_rise,
    output logic tick_fall
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] half_cnt;
    logic          wrap;

    // Half-period end detection
    assign wrap      = (half_cnt == CW'(HALF_CYC - 1));
    assign tick_rise = wrap && !ph;
    assign tick_fall = wrap && ph;

    // Half-period counter and phase toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            ph       <= 1'b0;
        end else if (wrap) begin
            half_cnt <= '0;
            ph       <= ~ph;
        end else begin
            half_cnt <= half_cnt + CW'(1);
        end
    end

    a_r7_phase_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |=> ph);

endmodule

// File: rtl/cmdser_shifter.sv
// Transmit and receive shift registers.
// The transmit register is left-justified so its top bit is always the
// bit on the wire; the receive register fills from the bottom.
// Assumes: load, shift and sample are never needed in the same cycle as
// deliver for conflicting data (sequencer guarantees this).
module cmdser_shifter #(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cmd,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              load_data,
    input  logic [DATA_W-1:0] data,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              miso,
    input  logic              deliver,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int SR_W = (CMD_W > DATA_W) ? CMD_W : DATA_W;

    logic [SR_W-1:0]   tx_sr;
    logic [DATA_W-1:0] rx_sr;

    assign tx_bit = tx_sr[SR_W-1];

    // Transmit register: load a word or move the next bit to the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load_cmd) begin
            tx_sr <= SR_W'(cmd) << (SR_W - CMD_W);
        end else if (load_data) begin
            tx_sr <= SR_W'(data) << (SR_W - DATA_W);
        end else if (shift_en) begin
            tx_sr <= tx_sr << 1;
        end
    end

    // Receive register: take one sampled bit per rising serial edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (sample_en) begin
            rx_sr <= {rx_sr[DATA_W-2:0], miso};
        end
    end

    // Output word register and its one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= deliver;
            if (deliver) begin
                rx_data <= rx_sr;
            end
        end
    end

    a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/cmdser_seq.sv
// Transaction sequencer.
// Steps through command bits, optional select gaps, the read turnaround
// slot and the data words; every state change happens on a falling
// serial tick so select and data move with the clock low.
// Assumes: count and direction are latched at request time and the
// request is only taken in the idle state.
module cmdser_seq
    import cmdser_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_rise,
    input  logic             tick_fall,
    input  logic             start_valid,
    input  logic [CMD_W-1:0] start_cmd,
    input  logic [CNT_W-1:0] start_count,
    input  logic             start_write,
    input  logic [1:0]       mode,
    output logic             start_ready,
    output logic [CMD_W-1:0] cmd_q,
    output logic             load_cmd,
    output logic             load_data,
    output logic             shift_en,
    output logic             sample_en,
    output logic             word_done,
    output logic             ss_n,
    output logic             clk_en,
    output logic             mosi_en,
    output logic             done,
    output logic             wr_q,
    output logic             free_sel
);
    localparam int SR_W = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int BW   = $clog2(SR_W) + 1;

    state_e           state, state_n;
    mode_e            mode_q, mode_n;
    logic [CMD_W-1:0] cmd_n;
    logic [CNT_W-1:0] words, words_n;
    logic [BW-1:0]    bit_cnt, bit_n;
    logic             gap_cnt, gap_n;
    logic             turn_pend, turn_n;
    logic             wr_n, ss_n_n, clk_en_n, mosi_en_n, done_n;
    logic             go_phase2, go_gap, go_finish, enter_data;

    // Next-state and next-output decision
    always_comb begin
        state_n    = state;
        mode_n     = mode_q;
        cmd_n      = cmd_q;
        words_n    = words;
        bit_n      = bit_cnt;
        gap_n      = gap_cnt;
        turn_n     = turn_pend;
        wr_n       = wr_q;
        ss_n_n     = ss_n;
        clk_en_n   = clk_en;
        mosi_en_n  = mosi_en;
        done_n     = 1'b0;
        go_phase2  = 1'b0;
        go_gap     = 1'b0;
        go_finish  = 1'b0;
        enter_data = 1'b0;
        case (state)
            ST_IDLE: if (start_valid) begin
                cmd_n   = start_cmd;
                words_n = start_count;
                wr_n    = start_write;
                mode_n  = mode_e'(mode);
                turn_n  = !start_write;
                state_n = ST_ARM;
            end
            ST_ARM: if (tick_fall) begin
                ss_n_n    = 1'b0;
                clk_en_n  = 1'b1;
                mosi_en_n = 1'b1;
                bit_n     = BW'(CMD_W - 1);
                state_n   = ST_CMD;
            end
            ST_CMD: if (tick_fall) begin
                if (bit_cnt != '0)           bit_n = bit_cnt - BW'(1);
                else if (words == '0)        go_finish = 1'b1;
                else if (mode_q == MODE_JOIN) go_phase2 = 1'b1;
                else                         go_gap = 1'b1;
            end
            ST_GAP: if (tick_fall) begin
                if (gap_cnt) begin
                    gap_n = 1'b0;
                end else begin
                    ss_n_n    = 1'b0;
                    go_phase2 = 1'b1;
                end
            end
            ST_TURN: if (tick_fall) begin
                enter_data = 1'b1;
            end
            ST_DATA: if (tick_fall) begin
                if (bit_cnt != '0) begin
                    bit_n = bit_cnt - BW'(1);
                end else begin
                    words_n = words - CNT_W'(1);
                    if (words == CNT_W'(1))         go_finish  = 1'b1;
                    else if (mode_q == MODE_JOIN)   enter_data = 1'b1;
                    else                            go_gap     = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (go_phase2) begin
            if (turn_pend) begin
                turn_n    = 1'b0;
                clk_en_n  = 1'b1;
                mosi_en_n = 1'b0;
                state_n   = ST_TURN;
            end else begin
                enter_data = 1'b1;
            end
        end
        if (enter_data) begin
            bit_n     = BW'(DATA_W - 1);
            clk_en_n  = 1'b1;
            mosi_en_n = wr_q;
            state_n   = ST_DATA;
        end
        if (go_gap) begin
            ss_n_n    = 1'b1;
            clk_en_n  = 1'b0;
            mosi_en_n = 1'b0;
            gap_n     = (mode_q == MODE_GAP2);
            state_n   = ST_GAP;
        end
        if (go_finish) begin
            ss_n_n    = 1'b1;
            clk_en_n  = 1'b0;
            mosi_en_n = 1'b0;
            done_n    = 1'b1;
            state_n   = ST_IDLE;
        end
    end

    // State and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode_q    <= MODE_PLAIN;
            cmd_q     <= '0;
            words     <= '0;
            bit_cnt   <= '0;
            gap_cnt   <= 1'b0;
            turn_pend <= 1'b0;
            wr_q      <= 1'b0;
            ss_n      <= 1'b1;
            clk_en    <= 1'b0;
            mosi_en   <= 1'b0;
            done      <= 1'b0;
        end else begin
            state     <= state_n;
            mode_q    <= mode_n;
            cmd_q     <= cmd_n;
            words     <= words_n;
            bit_cnt   <= bit_n;
            gap_cnt   <= gap_n;
            turn_pend <= turn_n;
            wr_q      <= wr_n;
            ss_n      <= ss_n_n;
            clk_en    <= clk_en_n;
            mosi_en   <= mosi_en_n;
            done      <= done_n;
        end
    end

    // Strobes to the shifter and the edge of the block
    assign start_ready = (state == ST_IDLE);
    assign load_cmd    = (state == ST_ARM) && tick_fall;
    assign load_data   = enter_data && wr_q;
    assign shift_en    = tick_fall && (bit_cnt != '0) &&
                         ((state == ST_CMD) || ((state == ST_DATA) && wr_q));
    assign sample_en   = tick_rise && (state == ST_DATA) && !wr_q;
    assign word_done   = tick_fall && (state == ST_DATA) && (bit_cnt == '0) && !wr_q;
    assign free_sel    = (state == ST_IDLE) ? (mode == MODE_FREE) : (mode_q == MODE_FREE);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ss_n && !$past(ss_n)));
    a_r8_join_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_JOIN && state != ST_IDLE && state != ST_ARM) |-> !ss_n);
    a_r10_ready_only_released: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> ss_n);

endmodule

// File: rtl/cmdser_master.sv
// Command-then-data serial master, top level.
// Joins the phase generator, the sequencer and the shift registers and
// forms the serial clock: the phase is passed through while bits move,
// or always when free-running is selected.
// Assumes: miso changes only while sclk is low; HALF_CYC >= 1.
module cmdser_master #(
    parameter int CMD_W    = 8,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 8,
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [CMD_W-1:0]  start_cmd,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              start_write,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] tx_word,
    output logic              tx_take,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              done,
    output logic              sclk,
    output logic              ss_n,
    output logic              mosi,
    input  logic              miso
);
    logic             ph, tick_rise, tick_fall;
    logic [CMD_W-1:0] cmd_q;
    logic             load_cmd, load_data, shift_en, sample_en, word_done;
    logic             clk_en, mosi_en, wr_q, free_sel, tx_bit;

    cmdser_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    cmdser_seq #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_rise   (tick_rise),
        .tick_fall   (tick_fall),
        .start_valid (start_valid),
        .start_cmd   (start_cmd),
        .start_count (start_count),
        .start_write (start_write),
        .mode        (mode),
        .start_ready (start_ready),
        .cmd_q       (cmd_q),
        .load_cmd    (load_cmd),
        .load_data   (load_data),
        .shift_en    (shift_en),
        .sample_en   (sample_en),
        .word_done   (word_done),
        .ss_n        (ss_n),
        .clk_en      (clk_en),
        .mosi_en     (mosi_en),
        .done        (done),
        .wr_q        (wr_q),
        .free_sel    (free_sel)
    );

    cmdser_shifter #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_cmd  (load_cmd),
        .cmd       (cmd_q),
        .load_data (load_data),
        .data      (tx_word),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .miso      (miso),
        .deliver   (word_done),
        .tx_bit    (tx_bit),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    // Serial outputs: gated clock and gated data bit
    assign sclk    = ph && (clk_en || free_sel);
    assign mosi    = mosi_en && tx_bit;
    assign tx_take = load_data;

    a_r5_clock_low_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n && !free_sel) |-> !sclk);
    a_r2_mosi_steady_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    a_r3_no_rx_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !wr_q);

endmodule

// File: tb/cmdser_master_bench.sv
module cmdser_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_valid = 1'b0;
    logic       start_ready;
    logic [7:0] start_cmd = 8'h00;
    logic [7:0] start_count = 8'h00;
    logic       start_write = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] tx_word;
    logic       tx_take;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       done;
    logic       sclk, ss_n, mosi;
    logic       miso = 1'b0;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    cmdser_master #(.CMD_W(8), .DATA_W(8), .CNT_W(8), .HALF_CYC(HALF)) u_cmdser_master (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .start_cmd(start_cmd), .start_count(start_count), .start_write(start_write),
        .mode(mode), .tx_word(tx_word), .tx_take(tx_take), .rx_data(rx_data),
        .rx_valid(rx_valid), .done(done), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] tx_val(int i);
        return 8'hA5 ^ 8'(i * 29);
    endfunction

    function automatic logic [7:0] resp_val(logic [7:0] c, int k);
        return (8'h3C + 8'(k * 81)) ^ c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // transmit source: advances on every take
    int tx_idx = 0;
    assign tx_word = tx_val(tx_idx);
    always @(posedge clk) if (tx_take) tx_idx <= tx_idx + 1;

    // peripheral model on the serial pins
    bit         capq[$];
    logic [7:0] cur_cmd;
    bit         cur_wr;
    int         cur_n;
    always @(posedge sclk) if (!ss_n) capq.push_back(mosi);
    always @(negedge sclk) begin
        int i;
        i = capq.size() - 9;
        if (!cur_wr && i >= 0 && i < 8 * cur_n)
            miso <= resp_val(cur_cmd, i / 8)[7 - (i % 8)];
        else
            miso <= 1'b0;
    end

    // select framing monitor
    int  frames, hi_run;
    int  gaps[$];
    bit  prev_ss = 1'b1;
    always @(negedge clk) begin
        if (!start_ready) begin
            if (ss_n) begin
                if (frames > 0) hi_run++;
            end else if (prev_ss) begin
                if (frames > 0) gaps.push_back(hi_run);
                frames++;
                hi_run = 0;
            end
        end
        prev_ss = ss_n;
    end

    // scoreboard monitor for received words
    logic [7:0] exp_q[$];
    always @(negedge clk) begin
        if (rx_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected rx word", rx_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_data == e, "R3", "rx word", rx_data, e);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic run_txn(input logic [7:0] c, input int n, input bit wr,
                           input logic [1:0] md, input bit poke);
        int tx_base, takes, waited, exp_frames, exp_edges, exp_gap;
        bit seen_done;
        string rq;
        @(negedge clk);
        capq.delete();
        gaps.delete();
        frames = 0;
        hi_run = 0;
        cur_cmd = c;
        cur_wr = wr;
        cur_n = n;
        tx_base = tx_idx;
        if (!wr) for (int k = 0; k < n; k++) exp_q.push_back(resp_val(c, k));
        start_cmd = c; start_count = 8'(n); start_write = wr; mode = md;
        start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        start_cmd = ~c;
        takes = 0; waited = 0; seen_done = 0;
        while (!seen_done && waited < 4000) begin
            @(negedge clk);
            waited++;
            if (tx_take) takes++;
            if (poke && waited == 20) start_valid = 1'b1;   // R10: request while busy
            if (poke && waited == 22) start_valid = 1'b0;
            if (done) begin
                seen_done = 1;
                chk(ss_n == 1'b1, "R9", "select high with done", ss_n, 1);
                @(negedge clk);
                chk(done == 1'b0, "R9", "done single cycle", done, 0);
            end
        end
        chk(seen_done, "R9", "done seen", seen_done, 1);
        rq = (md == 2'b11) ? "R8" : (md == 2'b01) ? "R6" : (md == 2'b10) ? "R7" : "R5";
        exp_frames = (n == 0 || md == 2'b11) ? 1 : 1 + n;
        chk(frames == exp_frames, rq, "select assertions", frames, exp_frames);
        exp_gap = (md == 2'b01) ? 4 * HALF : 2 * HALF;
        foreach (gaps[g]) chk(gaps[g] == exp_gap, rq, "gap length", gaps[g], exp_gap);
        exp_edges = 8 + ((n > 0 && !wr) ? 1 : 0) + 8 * n;
        chk(capq.size() == exp_edges, (n == 0) ? "R11" : "R3", "clock edges under select",
            capq.size(), exp_edges);
        if (capq.size() >= 8) begin
            logic [7:0] got;
            for (int b = 0; b < 8; b++) got[7 - b] = capq[b];
            chk(got == c, "R2", "command bits", got, c);
        end
        if (wr) begin
            chk(takes == n, "R4", "take strobes", takes, n);
            for (int k = 0; k < n; k++) begin
                logic [7:0] w;
                w = 8'h00;
                for (int b = 0; b < 8; b++)
                    if (8 + 8 * k + b < capq.size()) w[7 - b] = capq[8 + 8 * k + b];
                chk(w == tx_val(tx_base + k), "R4", "written word", w, tx_val(tx_base + k));
            end
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "all rx words delivered", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        int changes;
        logic last;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(ss_n == 1'b1 && sclk == 1'b0 && done == 1'b0 && rx_valid == 1'b0,
            "R1", "reset outputs", {ss_n, sclk, done, rx_valid}, 4'b1000);
        chk(start_ready == 1'b1, "R1", "ready after reset", start_ready, 1);

        // R1: plain idle keeps the clock still
        changes = 0; last = sclk;
        repeat (20) begin @(negedge clk); if (sclk != last) changes++; last = sclk; end
        chk(changes == 0, "R1", "idle clock still", changes, 0);

        run_txn(8'h96, 2, 1'b0, 2'b00, 1'b0);   // R5 read
        run_txn(8'h3A, 3, 1'b1, 2'b00, 1'b0);   // R5 R4 write
        run_txn(8'hC1, 2, 1'b0, 2'b01, 1'b0);   // R6 read
        run_txn(8'h5E, 2, 1'b1, 2'b01, 1'b0);   // R6 write

        // R7: free-running clock toggles while idle
        mode = 2'b10;
        @(negedge clk);
        changes = 0; last = sclk;
        repeat (20) begin @(negedge clk); if (sclk != last) changes++; last = sclk; end
        chk(changes >= 8, "R7", "free clock toggles idle", changes, 10);
        run_txn(8'h71, 1, 1'b0, 2'b10, 1'b0);   // R7 read
        mode = 2'b00;

        run_txn(8'hE4, 3, 1'b0, 2'b11, 1'b0);   // R8 read joined
        run_txn(8'h0F, 2, 1'b1, 2'b11, 1'b0);   // R8 write joined
        run_txn(8'hB2, 0, 1'b0, 2'b00, 1'b0);   // R11 command only
        run_txn(8'h29, 0, 1'b1, 2'b11, 1'b0);   // R11 joined, command only

        // R10: request pulsed while busy is ignored
        run_txn(8'h6D, 1, 1'b0, 2'b00, 1'b1);
        changes = 0;
        repeat (40) begin @(negedge clk); if (!ss_n || !start_ready) changes++; end
        chk(changes == 0, "R10", "no transaction from busy request", changes, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule